// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. A 16-bit up-counter advances once per prescaled tick while the timer is enabled. When the counter wraps from its maximum value back to zero, the block raises a reset request for a fixed number of bus clocks. Software sets a timeout of N ticks by loading 65536 − N into the counter and then enabling the timer. It keeps the system alive by reloading the counter before the wrap.

Every register write must carry a key in its upper bits, and the key differs between the counter and the control registers. A write with the wrong key is dropped. A loaded count does not reach the counting logic at once: a busy flag stays high for a fixed number of prescaled ticks, then clears on the cycle the value lands. An overflow flag records that a timeout happened. It survives the warm reset that the timeout causes, and only a keyed clear or a power-on reset removes it.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset (`rst_n` low), the counter reads 0, control A (offset 4) reads 0, control B (offset 8) reads 0, and `rst_req` is low.
- R2: A write to offset 0 whose bits 31:16 equal 0x5A5A is accepted. The busy flag (control A bit 5) reads 1 from the next cycle. After SYNC_TICKS prescaled ticks, the counter holds bits 15:0 of that write, and the busy flag reads 0 in the same cycle.
- R3: A write to offset 4 or 8 whose bits 31:8 equal 0xA5A5A5 is accepted. Control B stores bits 7:0 and reads them back. Control A takes the enable bit from bit 7 and the prescaler select from bits 2:0.
- R4: A write with the wrong key for its register, or a write to any offset other than 0, 4 or 8, changes no register. Reads of undefined offsets return 0.
- R5: While enabled, the counter advances by exactly one every D bus clocks, where D is 1, 4, 16, 32, 64, 128, 1024 or 4096 for select values 0 to 7. A read of offset 0 returns the live count in bits 15:0.
- R6: While the enable bit is 0, the counter does not change, except through a load.
- R7: On a tick that finds the enabled counter at 0xFFFF, the counter becomes 0, the overflow flag (control A bit 4) is set, the enable bit clears, and `rst_req` is high for exactly RST_CYCLES bus clocks.
- R8: The overflow flag is unchanged by the warm reset `wrst_n` and by a keyed write of 1 to bit 4. It is cleared by a keyed write of 0 to bit 4, or by power-on reset.
- R9: When an overflow and a keyed control A write fall in the same cycle, the overflow wins for the enable bit and the overflow flag. The prescaler select still takes the written value.
- R10: A warm reset pulse clears the counter, the enable bit, the prescaler select, control B and any pending load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst_n | input | 1 | Warm reset, synchronous, active low; leaves the overflow flag |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data including key |
| rdata | output | 32 | Read data for `addr` |
| rst_req | output | 1 | Reset request pulse after a timeout |

## Verification
Two events can land on the same clock edge: a counter wrap and a software write to control A that sets the enable bit and clears the overflow flag. The bench loads 0xFFFF with the fastest prescaler, enables the timer, and then issues that write on exactly the edge where the wrap happens. Afterwards, control A must read with the flag set, enable low and the newly written select, and `rst_req` must be high. The other checks sweep all eight prescaler settings and measure the count rate over whole periods. They also measure the busy window and the reset pulse to the cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int CSR_W  = 8;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 12;

  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CSR = 24'hA5A5A5;

  localparam int OFS_CNT  = 0;
  localparam int OFS_CSRA = 4;
  localparam int OFS_CSRB = 8;

  localparam int BIT_EN   = 7;
  localparam int BIT_BUSY = 5;
  localparam int BIT_OVF  = 4;

  // log2 of the prescaler divisor for each select code
  function automatic logic [3:0] div_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    div_shift = 4'd0;
      3'd1:    div_shift = 4'd2;
      3'd2:    div_shift = 4'd4;
      3'd3:    div_shift = 4'd5;
      3'd4:    div_shift = 4'd6;
      3'd5:    div_shift = 4'd7;
      3'd6:    div_shift = 4'd10;
      default: div_shift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = ~({PRE_W{1'b1}} << div_shift(sel));
    tick = ((pre_q & mask) == mask);
    pre_d = wrst_n ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             ovf_evt
);
  localparam int PW = $clog2(SYNC_TICKS + 1);

  logic [PW-1:0]    pend_q, pend_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             load_now;

  always_comb begin
    load_now = tick && (pend_q == PW'(1)) && !wr_cnt;
    ovf_evt  = wrst_n && en && tick && !load_now && (count_q == {CNT_W{1'b1}});
    pend_d   = pend_q;
    val_d    = val_q;
    count_d  = count_q;
    if (!wrst_n) begin
      pend_d  = '0;
      val_d   = '0;
      count_d = '0;
    end else begin
      if (wr_cnt) begin
        pend_d = PW'(SYNC_TICKS);
        val_d  = wr_val;
      end else if (tick && pend_q != '0) begin
        pend_d = pend_q - 1'b1;
      end
      if (load_now)         count_d = val_q;
      else if (en && tick)  count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      val_q   <= '0;
      count_q <= '0;
    end else begin
      pend_q  <= pend_d;
      val_q   <= val_d;
      count_q <= count_d;
    end
  end

  assign count = count_q;
  assign busy  = (pend_q != '0);

  // R7: a wrap leaves the counter at zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count_q == '0));
  // R6: no enable and no load keeps the count
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wrst_n && !en && !load_now) |=> $stable(count_q));
  // R2: an accepted load raises busy
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && wrst_n) |=> busy);
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  output logic rst_req
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ovf_evt)          cnt_d = RW'(RST_CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rst_req = (cnt_q != '0);

  // R7: the request follows the wrap on the next cycle
  a_r7_req_start: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> rst_req);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_evt,
  input  logic              busy,
  input  logic [CNT_W-1:0]  count,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic              wr_cnt,
  output logic [CNT_W-1:0]  wr_val,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CSRA = ADDR_W'(OFS_CSRA);
  localparam logic [ADDR_W-1:0] A_CSRB = ADDR_W'(OFS_CSRB);

  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CSR_W-1:0] csrb_q, csrb_d;
  logic             ovf_q, ovf_d;
  logic             key_cnt_ok, key_csr_ok, hit_csra, hit_csrb;

  always_comb begin
    key_cnt_ok = (wdata[31:16] == KEY_CNT);
    key_csr_ok = (wdata[31:8] == KEY_CSR);
    wr_cnt     = wrst_n && wr_en && (addr == A_CNT) && key_cnt_ok;
    hit_csra   = wrst_n && wr_en && (addr == A_CSRA) && key_csr_ok;
    hit_csrb   = wrst_n && wr_en && (addr == A_CSRB) && key_csr_ok;
    wr_val     = wdata[CNT_W-1:0];

    en_d   = en_q;
    sel_d  = sel_q;
    csrb_d = csrb_q;
    ovf_d  = ovf_q;
    if (!wrst_n) begin
      en_d   = 1'b0;
      sel_d  = '0;
      csrb_d = '0;
    end else begin
      if (hit_csra) begin
        en_d  = wdata[BIT_EN];
        sel_d = wdata[SEL_W-1:0];
      end
      if (ovf_evt) en_d = 1'b0;
      if (hit_csrb) csrb_d = wdata[CSR_W-1:0];
    end
    if (hit_csra && !wdata[BIT_OVF]) ovf_d = 1'b0;
    if (ovf_evt)                     ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      csrb_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      csrb_q <= csrb_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT:  rdata[CNT_W-1:0] = count;
      A_CSRA: begin
        rdata[BIT_EN]      = en_q;
        rdata[BIT_BUSY]    = busy;
        rdata[BIT_OVF]     = ovf_q;
        rdata[SEL_W-1:0]   = sel_q;
      end
      A_CSRB: rdata[CSR_W-1:0] = csrb_q;
      default: rdata = '0;
    endcase
  end

  assign en  = en_q;
  assign sel = sel_q;

  // R7: a wrap drops the enable bit
  a_r7_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !en_q);
  // R8: the flag holds unless a keyed clear arrives
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(hit_csra && !wdata[BIT_OVF])) |=> ovf_q);
  // R4: control B moves only on a keyed write to its offset
  a_r4_csrb_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wrst_n && !hit_csrb) |=> $stable(csrb_q));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SYNC_TICKS = 2,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rst_req
);
  logic             tick, en, wr_cnt, busy, ovf_evt;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] wr_val, count;

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wrst_n(wrst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .ovf_evt(ovf_evt), .busy(busy), .count(count),
    .en(en), .sel(sel), .wr_cnt(wr_cnt), .wr_val(wr_val), .rdata(rdata)
  );

  wdt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .wrst_n(wrst_n), .sel(sel), .tick(tick)
  );

  wdt_count #(.SYNC_TICKS(SYNC_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wrst_n(wrst_n), .tick(tick), .en(en),
    .wr_cnt(wr_cnt), .wr_val(wr_val), .count(count), .busy(busy),
    .ovf_evt(ovf_evt)
  );

  wdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .rst_req(rst_req)
  );
endmodule

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n, wrst_n, wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rst_req;
  int checks = 0;
  int fails  = 0;
  logic [31:0] d, d0, d1;

  keyed_wdt dut (
    .clk(clk), .rst_n(rst_n), .wrst_n(wrst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(4'd4, s);
      if (s[5] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  function automatic int divisor(input int c);
    int t[8] = '{1, 4, 16, 32, 64, 128, 1024, 4096};
    return t[c];
  endfunction

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int highs;
    rst_n = 1'b0; wrst_n = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, d); chk("R1 count", d, 32'h0);
    rd(4'd4, d); chk("R1 ctrlA", d, 32'h0);
    rd(4'd8, d); chk("R1 ctrlB", d, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

    // R3 keyed control writes
    wr(4'd8, 32'hA5A5A53C); rd(4'd8, d); chk("R3 ctrlB", d, 32'h3C);
    wr(4'd4, 32'hA5A5A500); rd(4'd4, d); chk("R3 ctrlA", d, 32'h0);

    // R2 counter load through busy window (select 0: tick each clock)
    wr(4'd0, 32'h5A5A1234);
    rd(4'd4, d); chk("R2 busy set", {31'b0, d[5]}, 32'h1);
    rd(4'd0, d); chk("R2 old count", d, 32'h0);
    @(negedge clk);
    rd(4'd4, d); chk("R2 busy held", {31'b0, d[5]}, 32'h1);
    @(negedge clk);
    rd(4'd4, d); chk("R2 busy clear", {31'b0, d[5]}, 32'h0);
    rd(4'd0, d); chk("R2 loaded", d, 32'h1234);

    // R4 bad keys and undefined offset
    wr(4'd0, 32'h5A5B0055);
    rd(4'd4, d); chk("R4 no busy", {31'b0, d[5]}, 32'h0);
    repeat (4) @(negedge clk);
    rd(4'd0, d); chk("R4 count kept", d, 32'h1234);
    wr(4'd8, 32'hA5A5A477); rd(4'd8, d); chk("R4 ctrlB kept", d, 32'h3C);
    wr(4'd4, 32'h5A5A0087); rd(4'd4, d); chk("R4 ctrlA kept", d, 32'h0);
    wr(4'd12, 32'hA5A5A587);
    rd(4'd12, d); chk("R4 undef read", d, 32'h0);
    rd(4'd4, d);  chk("R4 undef ctrlA", d, 32'h0);
    rd(4'd8, d);  chk("R4 undef ctrlB", d, 32'h3C);
    rd(4'd0, d);  chk("R4 undef count", d, 32'h1234);

    // R5 / R6 rate sweep over every prescaler select
    for (int c = 0; c < 8; c++) begin
      wr(4'd0, 32'h5A5A0000);
      wait_idle();
      wr(4'd4, 32'hA5A5A580 | c);
      rd(4'd0, d0);
      repeat (3 * divisor(c)) @(negedge clk);
      rd(4'd0, d1);
      chk($sformatf("R5 rate sel%0d", c), d1 - d0, 32'd3);
      wr(4'd4, 32'hA5A5A500 | c);
      rd(4'd0, d0);
      repeat (2 * divisor(c) + 3) @(negedge clk);
      rd(4'd0, d1);
      chk($sformatf("R6 stopped sel%0d", c), d1, d0);
    end

    // R7 overflow
    wr(4'd4, 32'hA5A5A500);
    wr(4'd0, 32'h5A5AFFFE);
    wait_idle();
    wr(4'd4, 32'hA5A5A580);
    rd(4'd0, d); chk("R7 pre count", d, 32'hFFFE);
    @(negedge clk);
    rd(4'd0, d); chk("R7 max count", d, 32'hFFFF);
    chk("R7 no req yet", {31'b0, rst_req}, 32'h0);
    @(negedge clk);
    rd(4'd0, d); chk("R7 wrapped", d, 32'h0);
    rd(4'd4, d); chk("R7 flag set en clear", d, 32'h10);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      if (rst_req) highs++;
      @(negedge clk);
    end
    chk("R7 pulse length", highs, 32'd16);

    // R8 / R10 warm reset keeps the flag
    wr(4'd8, 32'hA5A5A555);
    wr(4'd4, 32'hA5A5A593);
    rd(4'd4, d); chk("R8 write one keeps", d, 32'h93);
    wr(4'd0, 32'h5A5A4321);
    @(negedge clk); wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
    rd(4'd4, d); chk("R8 flag after warm", d, 32'h10);
    rd(4'd8, d); chk("R10 ctrlB cleared", d, 32'h0);
    rd(4'd0, d); chk("R10 count cleared", d, 32'h0);
    repeat (4) @(negedge clk);
    rd(4'd0, d); chk("R10 pending dropped", d, 32'h0);
    wr(4'd4, 32'hA5A5A500);
    rd(4'd4, d); chk("R8 keyed clear", d, 32'h0);

    // R9 wrap and control write on the same edge
    wr(4'd0, 32'h5A5AFFFF);
    wait_idle();
    wr(4'd4, 32'hA5A5A580);
    wr_en = 1'b1; addr = 4'd4; wdata = 32'hA5A5A581;
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'd4, d); chk("R9 overflow wins", d, 32'h11);
    rd(4'd0, d); chk("R9 count wrapped", d, 32'h0);
    chk("R9 req", {31'b0, rst_req}, 32'h1);

    // R8 power-on reset clears the flag
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(4'd4, d); chk("R8 por clears flag", d, 32'h0);
    chk("R1 req after por", {31'b0, rst_req}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule